// File: doc/BRIEF.md
# Log-Depth Zero-Run Counter

This block is purely combinational. It returns the number of zero bits that come before the first set bit of an N-bit operand. Two mode inputs choose where the scan starts:

- **Leading mode** scans from the most significant bit.
- **Trailing mode** scans from the least significant bit.

Trailing mode is built by bit-reversing the operand and then running the same leading-zero network. That network is a binary tree of merge nodes that halves the candidate range at each level. For an operand of 2^k bits it uses 2^k − 1 word multiplexers and k multiplexer levels, not a serial scan.

Two output variants are offered:

- **Full variant**: the result is clog2(N+1) bits wide, and an all-zero operand reports N.
- **Short variant**: the result is clog2(N) bits wide. Its value for an all-zero operand is unspecified, so callers that already know the operand is non-zero save one bit.

For an N that is not a power of two, the operand is padded with zeros up to the next power of two, on the side away from the scan start. A subtraction then removes the pad from the all-zero count. A power-of-two N has no subtractor. N must be at least 4. If neither mode input is high, the result is forced to zero.

Top module: `zero_run_counter`

## Requirements
- R1: With `lead_en`=1, the result for a non-zero operand equals the number of zero bits above its highest set bit (0 when `operand[N-1]`=1).
- R2: With `lead_en`=0 and `trail_en`=1, the result for a non-zero operand equals the number of zero bits below its lowest set bit (0 when `operand[0]`=1).
- R3: When `lead_en` and `trail_en` are both 1, leading mode takes priority and the result equals the R1 value.
- R4: When both `lead_en` and `trail_en` are 0, every bit of `count` is 0, whatever the operand.
- R5: In the full variant (`VARIANT`=VAR_FULL), `count` is clog2(N+1) bits wide, and an all-zero operand in either mode gives `count`=N. For a power-of-two N this is only the top bit set.
- R6: In the short variant (`VARIANT`=VAR_SHORT), `count` is clog2(N) bits wide and carries the R1/R2/R3 value for every non-zero operand.
- R7: For an N that is not a power of two (for example 13), both variants give the same counts as R1 to R5, including N for an all-zero operand in the full variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lead_en | input | 1 | Count from the MSB downward; has priority |
| trail_en | input | 1 | Count from the LSB upward |
| operand | input | N | Word to scan |
| count | output | OW (clog2(N+1) full, clog2(N) short) | Zero-run length, or 0 when no mode is selected |

## Verification
The in-line assertions assume the operand and the mode inputs are settled to known values whenever they are evaluated. The tree-level checks also assume the padded region on the far side of the scan holds only zeros, which the steering stage guarantees.

The stimulus only drives defined 0/1 values. It never checks the short variant's value for an all-zero operand, because that value is left open.

Every 16-bit operand is applied in both modes. This covers the 8-bit and 13-bit instances exhaustively through the low slices. Random wide operands, shifted to create long zero runs, then exercise the 64-bit instances with all four mode combinations.

// File: rtl/zrc_pkg.sv
package zrc_pkg;

    typedef enum logic {
        VAR_SHORT = 1'b0,
        VAR_FULL  = 1'b1
    } zrc_variant_e;

    // Operand width rounded up to the next power of two
    function automatic int padded_width(input int n);
        return 1 << $clog2(n);
    endfunction

    // Width of the count port for a given variant
    function automatic int result_width(input int n, input zrc_variant_e v);
        return (v == VAR_FULL) ? $clog2(n + 1) : $clog2(n);
    endfunction

endpackage

// File: rtl/zrc_steer.sv
// Orients the operand so that the scan always starts at the top bit,
// then pads with zeros on the far side up to a power of two.
module zrc_steer #(
    parameter int N = 16,
    parameter int P = 16
) (
    input  logic [N-1:0] operand,
    input  logic         lead_sel,
    output logic [P-1:0] vec
);
    logic [N-1:0] flipped;
    logic [N-1:0] picked;

    for (genvar i = 0; i < N; i++) begin : g_flip
        assign flipped[i] = operand[N-1-i];
    end

    assign picked = lead_sel ? operand : flipped;

    if (P == N) begin : g_exact
        assign vec = picked;
    end else begin : g_pad
        assign vec = {picked, {(P-N){1'b0}}};
    end

    always_comb begin
        // The first scanned bit is the MSB in leading mode and the LSB in trailing mode
        assert_scan_start_R2: assert (vec[P-1] == (lead_sel ? operand[N-1] : operand[0]));
    end
endmodule

// File: rtl/zrc_tree.sv
// Recursive halving network: level l holds P>>l nodes, each one merging
// two children with a single word multiplexer.
module zrc_tree #(
    parameter  int P = 16,
    localparam int K = $clog2(P)
) (
    input  logic [P-1:0] vec,
    output logic         root_vld,
    output logic [K-1:0] root_cnt
);
    for (genvar l = 0; l <= K; l++) begin : g_lvl
        localparam int W = P >> l;
        logic [W-1:0] v;
        logic [K-1:0] c [W];

        if (l == 0) begin : g_leaf
            // Node 0 sits at the scan start
            for (genvar i = 0; i < W; i++) begin : g_bit
                assign v[i] = vec[P-1-i];
                assign c[i] = '0;
            end
        end else begin : g_merge
            for (genvar j = 0; j < W; j++) begin : g_node
                assign v[j] = g_lvl[l-1].v[2*j] | g_lvl[l-1].v[2*j+1];
                assign c[j] = g_lvl[l-1].v[2*j] ? g_lvl[l-1].c[2*j]
                                                : (g_lvl[l-1].c[2*j+1] | K'(1 << (l-1)));
            end
        end
    end

    assign root_vld = g_lvl[K].v[0];
    assign root_cnt = g_lvl[K].c[0];

    always_comb begin
        assert_root_flag_R1: assert (root_vld == (|vec));
        if (root_vld) begin
            assert_first_one_R1: assert (vec[P-1-int'(root_cnt)] &&
                                         ((vec >> (P - int'(root_cnt))) == '0));
        end
    end
endmodule

// File: rtl/zrc_fixup.sv
// Turns the tree root into the port value: all-zero handling, pad
// correction for non-power-of-two widths, variant trim and mode gating.
module zrc_fixup #(
    parameter int                   N       = 16,
    parameter int                   K       = 4,
    parameter zrc_pkg::zrc_variant_e VARIANT = zrc_pkg::VAR_FULL,
    parameter int                   OW      = 5
) (
    input  logic          root_vld,
    input  logic [K-1:0]  root_cnt,
    input  logic          gate,
    output logic [OW-1:0] result
);
    localparam int P   = 1 << K;
    localparam int PAD = P - N;

    logic [OW-1:0] shaped;

    if (VARIANT == zrc_pkg::VAR_FULL) begin : g_full
        logic [K:0] raw;
        logic [K:0] adj;
        assign raw = root_vld ? {1'b0, root_cnt} : (K+1)'(P);
        if (PAD == 0) begin : g_pow2
            assign adj = raw;
        end else begin : g_sub
            assign adj = raw - (root_vld ? (K+1)'(0) : (K+1)'(PAD));
            always_comb begin
                // A corrected count never exceeds N, so the spare top bit stays clear
                assert_no_overflow_R7: assert (adj[K] == 1'b0);
            end
        end
        assign shaped = adj[OW-1:0];
        always_comb begin
            if (gate && !root_vld) begin
                assert_zero_is_n_R5: assert (int'(result) == N);
            end
        end
    end else begin : g_short
        assign shaped = root_cnt;
    end

    assign result = gate ? shaped : '0;

    always_comb begin
        if (!gate) begin
            assert_idle_zero_R4: assert (result == '0);
        end
        if (gate && root_vld) begin
            assert_in_range_R6: assert (int'(result) < N);
        end
    end
endmodule

// File: rtl/zero_run_counter.sv
module zero_run_counter #(
    parameter  int                    N       = 16,
    parameter  zrc_pkg::zrc_variant_e VARIANT = zrc_pkg::VAR_FULL,
    localparam int                    OW      = zrc_pkg::result_width(N, VARIANT)
) (
    input  logic          lead_en,
    input  logic          trail_en,
    input  logic [N-1:0]  operand,
    output logic [OW-1:0] count
);
    localparam int P = zrc_pkg::padded_width(N);
    localparam int K = $clog2(P);

    logic [P-1:0] vec;
    logic         root_vld;
    logic [K-1:0] root_cnt;

    zrc_steer #(.N(N), .P(P)) u_steer (
        .operand  (operand),
        .lead_sel (lead_en),
        .vec      (vec)
    );

    zrc_tree #(.P(P)) u_tree (
        .vec      (vec),
        .root_vld (root_vld),
        .root_cnt (root_cnt)
    );

    zrc_fixup #(.N(N), .K(K), .VARIANT(VARIANT), .OW(OW)) u_fixup (
        .root_vld (root_vld),
        .root_cnt (root_cnt),
        .gate     (lead_en | trail_en),
        .result   (count)
    );

    always_comb begin
        if (lead_en && operand[N-1]) begin
            assert_top_bit_R3: assert (count == '0);
        end
        if (!lead_en && trail_en && operand[0]) begin
            assert_low_bit_R2: assert (count == '0);
        end
    end
endmodule

// File: tb/zero_run_counter_tb.sv
`timescale 1ns/1ps
module zero_run_counter_tb;
    import zrc_pkg::*;

    logic        clk = 1'b0;
    logic        lead_en = 1'b0;
    logic        trail_en = 1'b0;
    logic [63:0] stim = '0;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    logic [4:0] o16f; logic [3:0] o16s;
    logic [3:0] o8f;  logic [2:0] o8s;
    logic [6:0] o64f; logic [5:0] o64s;
    logic [3:0] o13f; logic [3:0] o13s;

    zero_run_counter #(.N(16), .VARIANT(VAR_FULL)) u_dut (
        .lead_en(lead_en), .trail_en(trail_en), .operand(stim[15:0]), .count(o16f));
    zero_run_counter #(.N(16), .VARIANT(VAR_SHORT)) u_dut_16s (
        .lead_en(lead_en), .trail_en(trail_en), .operand(stim[15:0]), .count(o16s));
    zero_run_counter #(.N(8), .VARIANT(VAR_FULL)) u_dut_8f (
        .lead_en(lead_en), .trail_en(trail_en), .operand(stim[7:0]), .count(o8f));
    zero_run_counter #(.N(8), .VARIANT(VAR_SHORT)) u_dut_8s (
        .lead_en(lead_en), .trail_en(trail_en), .operand(stim[7:0]), .count(o8s));
    zero_run_counter #(.N(64), .VARIANT(VAR_FULL)) u_dut_64f (
        .lead_en(lead_en), .trail_en(trail_en), .operand(stim), .count(o64f));
    zero_run_counter #(.N(64), .VARIANT(VAR_SHORT)) u_dut_64s (
        .lead_en(lead_en), .trail_en(trail_en), .operand(stim), .count(o64s));
    zero_run_counter #(.N(13), .VARIANT(VAR_FULL)) u_dut_13f (
        .lead_en(lead_en), .trail_en(trail_en), .operand(stim[12:0]), .count(o13f));
    zero_run_counter #(.N(13), .VARIANT(VAR_SHORT)) u_dut_13s (
        .lead_en(lead_en), .trail_en(trail_en), .operand(stim[12:0]), .count(o13s));

    // Serial scan over the low n bits
    function automatic int scan_model(logic [63:0] v, int n, bit from_top);
        for (int i = 0; i < n; i++) begin
            if (v[from_top ? (n - 1 - i) : i]) return i;
        end
        return n;
    endfunction

    task automatic judge(int n, bit full, int got, logic [63:0] v, bit c, bit t);
        int    expv;
        string tag;
        bit    zero;
        zero = (scan_model(v, n, 1'b1) == n);
        if (!(c | t)) begin
            tag  = "R4";
            expv = 0;
        end else begin
            if (!full && zero) return;  // value left open
            expv = scan_model(v, n, c);
            if (n == 13)   tag = "R7";
            else if (zero) tag = "R5";
            else if (!full) tag = "R6";
            else if (c && t) tag = "R3";
            else if (c)    tag = "R1";
            else           tag = "R2";
        end
        n_checks++;
        if (got != expv) begin
            n_fails++;
            $display("FAIL %s N=%0d full=%0d op=%h lead=%0d trail=%0d got=%0d exp=%0d",
                     tag, n, full, v, c, t, got, expv);
        end
    endtask

    task automatic apply(logic [63:0] v, bit c, bit t);
        stim = v; lead_en = c; trail_en = t;
        @(negedge clk);
        judge(16, 1, int'(o16f), v, c, t);
        judge(16, 0, int'(o16s), v, c, t);
        judge(8,  1, int'(o8f),  v, c, t);
        judge(8,  0, int'(o8s),  v, c, t);
        judge(64, 1, int'(o64f), v, c, t);
        judge(64, 0, int'(o64s), v, c, t);
        judge(13, 1, int'(o13f), v, c, t);
        judge(13, 0, int'(o13s), v, c, t);
        @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        @(posedge clk);
        // Idle state: no mode selected (R4)
        apply(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
        // All-zero operand in each mode (R5, R7)
        apply('0, 1'b1, 1'b0);
        apply('0, 1'b0, 1'b1);
        apply('0, 1'b1, 1'b1);
        // Single set bit at each end (R1, R2)
        apply(64'h8000_0000_0000_0001, 1'b1, 1'b0);
        apply(64'h8000_0000_0000_0001, 1'b0, 1'b1);
        apply(64'h0000_0000_0000_0001, 1'b1, 1'b0);
        apply(64'h8000_0000_0000_0000, 1'b0, 1'b1);
        // Both modes high: leading wins (R3)
        apply(64'h0000_0100_0010_0100, 1'b1, 1'b1);
        // Exhaustive over the low 16 bits, random upper bits, both modes (R1, R2, R6, R7)
        for (int x = 0; x < 65536; x++) begin
            logic [63:0] v;
            v = {$urandom(), $urandom()};
            v[15:0] = x[15:0];
            apply(v, 1'b1, 1'b0);
            apply(v, 1'b0, 1'b1);
        end
        // Random wide operands with long zero runs, all mode pairs (R1..R6)
        for (int k = 0; k < 6000; k++) begin
            logic [63:0] v;
            int          sh;
            v  = {$urandom(), $urandom()};
            sh = $urandom_range(0, 64);
            v  = (k % 2 == 0) ? (v >> sh) : (v << sh);
            apply(v, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired got=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule